// File: doc/BRIEF.md
# Sprite XOR Blitter with Collision Detect

This block draws a small monochrome sprite into a framebuffer that stores one bit per pixel. The framebuffer is organised as rows of bytes, and within each byte the most significant bit is the leftmost pixel. A single start pulse supplies everything the draw needs:

- a pixel coordinate pair,
- a row count,
- the address of the sprite in a source memory,
- a bit that selects the low- or high-resolution geometry,
- a bit that selects whether drawing wraps around the screen edges or is clipped at them.

The engine fetches sprite bytes through a read port. Each sprite row is aligned to the pixel column, so it usually spans one more framebuffer byte than it is wide. Each affected framebuffer byte is changed by a read-modify-write through a second port. Sprite pixels are combined with the screen by exclusive OR. Any pixel that turns from on to off raises a collision flag, which the caller reads when the done pulse appears.

Both memories have one cycle of read latency: data is presented the cycle after the read strobe. The engine serves one draw at a time and ignores new requests until the current draw has finished.

Top module: `sprite_blitter`

## Requirements
- R1: After reset, busy, done, collision, fb_rd, fb_we and spr_rd are all low.
- R2: Screen geometry is fixed by the mode bit.
  - Low resolution is 64x32 pixels and high resolution is 128x64 pixels.
  - A pixel (px, py) lives in byte py*(W/8) + px/8, where W is the screen width.
  - Within that byte the pixel is bit 7 - (px mod 8).
  - The start coordinates are first reduced modulo the screen width and height.
- R3: When the row count n is 1 to 15, the sprite is 8 pixels wide and n rows tall. Row r is the source byte at base + r, and its bit 7 is the leftmost pixel.
- R4: Each sprite row is shifted right by (X mod 8) and exclusive-ORed into the framebuffer byte at column X/8 and the byte after it. Every framebuffer write goes to an address inside the active screen.
- R5: The collision flag is 1 after a draw if any sprite bit of 1 landed on a framebuffer bit that was already 1. Otherwise it is 0.
- R6: The collision flag is cleared when a draw is accepted.
- R7: With the wrap bit set, column positions wrap modulo the width and rows wrap modulo the height.
- R8: With the wrap bit clear, pixels right of the last column or below the last row are not written. The framebuffer outside the drawn area is left unchanged.
- R9: When n is 0, in either mode, a 16x16 sprite is drawn. Row r comes from source bytes base + 2r (the left half) and base + 2r + 1 (the right half).
- R10: Busy is high from the cycle after an accepted start until done. Done is high for exactly one cycle, the cycle after the last framebuffer write.
- R11: A start pulse while busy is ignored. The draw in progress completes unchanged, and no second draw follows.
- R12: Memory port timing is fixed.
  - Read data is taken the cycle after the read strobe.
  - A framebuffer byte is written two cycles after it was read, at the same address.
  - At most one of spr_rd, fb_rd and fb_we is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a draw with the parameters below (accepted when idle) |
| x_in | input | 8 | X pixel coordinate |
| y_in | input | 8 | Y pixel coordinate |
| n_in | input | 4 | Sprite row count; 0 selects the 16x16 sprite |
| base_in | input | SRC_AW | Source address of the first sprite byte |
| hires_in | input | 1 | 1 selects 128x64, 0 selects 64x32 |
| wrap_in | input | 1 | 1 wraps at screen edges, 0 clips |
| spr_rd | output | 1 | Sprite memory read strobe |
| spr_addr | output | SRC_AW | Sprite memory address |
| spr_data | input | 8 | Sprite memory read data (one cycle after strobe) |
| fb_rd | output | 1 | Framebuffer read strobe |
| fb_we | output | 1 | Framebuffer write enable |
| fb_addr | output | FB_AW | Framebuffer byte address |
| fb_wdata | output | 8 | Framebuffer write data |
| fb_rdata | input | 8 | Framebuffer read data (one cycle after strobe) |
| busy | output | 1 | Draw in progress |
| done | output | 1 | One-cycle pulse at the end of a draw |
| collision | output | 1 | Set when a draw erased any pixel |

## Verification
Draws are tried in several situations, and each one isolates a different part of the behaviour:

- Byte-aligned and unaligned X positions separate the shift logic from the column selection.
- Repeating an identical draw must restore the screen and raise the collision flag. Following it with a draw onto an empty area shows that the flag is cleared.
- Sprites placed across the right and bottom edges, once with wrap and once without, separate the wrapping arithmetic from the clipping.
- Coordinates larger than the screen check the modulo reduction.
- 16x16 sprites in both modes check the two-byte fetch order and the three-byte span.
- A start pulse issued mid-draw with different parameters must leave no trace in the framebuffer and cause no extra done pulse.

// File: rtl/blit_pkg.sv
package blit_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SREQ,
    ST_SWAIT,
    ST_SCAP,
    ST_PLACE,
    ST_FWAIT,
    ST_FRMW,
    ST_FIN
  } blit_state_t;

endpackage

// File: rtl/sprite_shift_align.sv
module sprite_shift_align #(
  parameter int PIX_W = 16,
  parameter int LANES = PIX_W / 8 + 1
) (
  input  logic [PIX_W-1:0]          pix,
  input  logic [2:0]                off,
  output logic [LANES-1:0][7:0]     lanes
);
  localparam int WIN_W = LANES * 8;

  logic [WIN_W-1:0] window;

  // Sprite row padded on the right with one spare byte, then moved by the bit offset.
  assign window = {pix, {(WIN_W - PIX_W){1'b0}}} >> off;

  // Lane 0 is the leftmost framebuffer byte touched by the row.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = window[WIN_W-1-8*g -: 8];
  end
endmodule

// File: rtl/fb_addr_map.sv
module fb_addr_map #(
  parameter int LO_W  = 64,
  parameter int LO_H  = 32,
  parameter int HI_W  = 128,
  parameter int HI_H  = 64,
  parameter int FB_AW = 10,
  parameter int COL_W = 6,
  parameter int ROW_W = 7
) (
  input  logic             hires,
  input  logic             wrap,
  input  logic [COL_W-1:0] col_base,
  input  logic [1:0]       lane,
  input  logic [ROW_W-1:0] row_base,
  input  logic [4:0]       line,
  output logic [FB_AW-1:0] addr,
  output logic             skip
);
  localparam int LO_WB = LO_W / 8;
  localparam int HI_WB = HI_W / 8;

  logic [COL_W-1:0] col_raw;
  logic [ROW_W-1:0] row_raw;
  int wb_i, h_i, c_i, r_i;

  assign col_raw = col_base + COL_W'(lane);
  assign row_raw = row_base + ROW_W'(line);

  always_comb begin
    wb_i = hires ? HI_WB : LO_WB;
    h_i  = hires ? HI_H  : LO_H;
    c_i  = int'(col_raw);
    r_i  = int'(row_raw);
    skip = 1'b0;
    if (wrap) begin
      c_i = c_i % wb_i;
      r_i = r_i % h_i;
    end else begin
      skip = (c_i >= wb_i) || (r_i >= h_i);
    end
    addr = FB_AW'(r_i * wb_i + c_i);
  end
endmodule

// File: rtl/sprite_blitter.sv
module sprite_blitter
  import blit_pkg::*;
#(
  parameter int SRC_AW = 12,
  parameter int FB_AW  = 10,
  parameter int LO_W   = 64,
  parameter int LO_H   = 32,
  parameter int HI_W   = 128,
  parameter int HI_H   = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        x_in,
  input  logic [7:0]        y_in,
  input  logic [3:0]        n_in,
  input  logic [SRC_AW-1:0] base_in,
  input  logic              hires_in,
  input  logic              wrap_in,
  output logic              spr_rd,
  output logic [SRC_AW-1:0] spr_addr,
  input  logic [7:0]        spr_data,
  output logic              fb_rd,
  output logic              fb_we,
  output logic [FB_AW-1:0]  fb_addr,
  output logic [7:0]        fb_wdata,
  input  logic [7:0]        fb_rdata,
  output logic              busy,
  output logic              done,
  output logic              collision
);
  localparam int LO_WB    = LO_W / 8;
  localparam int HI_WB    = HI_W / 8;
  localparam int COL_W    = $clog2(HI_WB) + 2;
  localparam int ROW_W    = $clog2(HI_H) + 1;
  localparam int PIX_W    = 16;
  localparam int LANES    = PIX_W / 8 + 1;
  localparam int LO_BYTES = LO_WB * LO_H;
  localparam int HI_BYTES = HI_WB * HI_H;

  blit_state_t      st;
  logic [2:0]       xoff_q;
  logic [COL_W-1:0] xcol_q;
  logic [ROW_W-1:0] yrow_q;
  logic [SRC_AW-1:0] base_q;
  logic             big_q, hires_q, wrap_q;
  logic [4:0]       rows_q, row_q;
  logic             sb_q;
  logic [1:0]       k_q;
  logic [PIX_W-1:0] pix_q;

  logic [7:0]       xs_c, ys_c;
  logic [LANES-1:0][7:0] lanes;
  logic [7:0]       cur_byte;
  logic [FB_AW-1:0] map_addr;
  logic             map_skip;
  logic [1:0]       last_k;
  logic             last_row;

  // Start coordinates folded into the active screen.
  always_comb begin
    xs_c = hires_in ? 8'(32'(x_in) % HI_W) : 8'(32'(x_in) % LO_W);
    ys_c = hires_in ? 8'(32'(y_in) % HI_H) : 8'(32'(y_in) % LO_H);
  end

  sprite_shift_align #(.PIX_W(PIX_W), .LANES(LANES)) u_align (
    .pix   (pix_q),
    .off   (xoff_q),
    .lanes (lanes)
  );

  fb_addr_map #(
    .LO_W(LO_W), .LO_H(LO_H), .HI_W(HI_W), .HI_H(HI_H),
    .FB_AW(FB_AW), .COL_W(COL_W), .ROW_W(ROW_W)
  ) u_map (
    .hires    (hires_q),
    .wrap     (wrap_q),
    .col_base (xcol_q),
    .lane     (k_q),
    .row_base (yrow_q),
    .line     (row_q),
    .addr     (map_addr),
    .skip     (map_skip)
  );

  assign cur_byte = lanes[k_q];
  assign last_k   = big_q ? 2'd2 : 2'd1;
  assign last_row = (row_q == rows_q - 5'd1);
  assign busy     = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      xoff_q    <= '0;
      xcol_q    <= '0;
      yrow_q    <= '0;
      base_q    <= '0;
      big_q     <= 1'b0;
      hires_q   <= 1'b0;
      wrap_q    <= 1'b0;
      rows_q    <= '0;
      row_q     <= '0;
      sb_q      <= 1'b0;
      k_q       <= '0;
      pix_q     <= '0;
      spr_rd    <= 1'b0;
      spr_addr  <= '0;
      fb_rd     <= 1'b0;
      fb_we     <= 1'b0;
      fb_addr   <= '0;
      fb_wdata  <= '0;
      done      <= 1'b0;
      collision <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          fb_we <= 1'b0;
          if (start) begin
            xoff_q    <= xs_c[2:0];
            xcol_q    <= COL_W'(xs_c >> 3);
            yrow_q    <= ROW_W'(ys_c);
            base_q    <= base_in;
            big_q     <= (n_in == 4'd0);
            rows_q    <= (n_in == 4'd0) ? 5'd16 : {1'b0, n_in};
            hires_q   <= hires_in;
            wrap_q    <= wrap_in;
            row_q     <= '0;
            sb_q      <= 1'b0;
            k_q       <= '0;
            collision <= 1'b0;
            st        <= ST_SREQ;
          end
        end
        ST_SREQ: begin
          fb_we    <= 1'b0;
          spr_rd   <= 1'b1;
          spr_addr <= base_q + SRC_AW'(big_q ? {row_q, 1'b0} : {1'b0, row_q})
                      + SRC_AW'(sb_q);
          st       <= ST_SWAIT;
        end
        ST_SWAIT: begin
          spr_rd <= 1'b0;
          st     <= ST_SCAP;
        end
        ST_SCAP: begin
          if (!sb_q) begin
            pix_q <= {spr_data, 8'h00};
            if (big_q) begin
              sb_q <= 1'b1;
              st   <= ST_SREQ;
            end else begin
              k_q <= '0;
              st  <= ST_PLACE;
            end
          end else begin
            pix_q[7:0] <= spr_data;
            k_q        <= '0;
            st         <= ST_PLACE;
          end
        end
        ST_PLACE: begin
          fb_we <= 1'b0;
          if (map_skip) begin
            if (k_q != last_k) begin
              k_q <= k_q + 2'd1;
            end else if (!last_row) begin
              row_q <= row_q + 5'd1;
              sb_q  <= 1'b0;
              st    <= ST_SREQ;
            end else begin
              st <= ST_FIN;
            end
          end else begin
            fb_rd   <= 1'b1;
            fb_addr <= map_addr;
            st      <= ST_FWAIT;
          end
        end
        ST_FWAIT: begin
          fb_rd <= 1'b0;
          st    <= ST_FRMW;
        end
        ST_FRMW: begin
          fb_wdata <= fb_rdata ^ cur_byte;
          fb_we    <= 1'b1;
          if ((fb_rdata & cur_byte) != 8'h00) collision <= 1'b1;
          if (k_q != last_k) begin
            k_q <= k_q + 2'd1;
            st  <= ST_PLACE;
          end else if (!last_row) begin
            row_q <= row_q + 5'd1;
            sb_q  <= 1'b0;
            st    <= ST_SREQ;
          end else begin
            st <= ST_FIN;
          end
        end
        ST_FIN: begin
          fb_we <= 1'b0;
          done  <= 1'b1;
          st    <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10: done lasts a single cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: done only ends a draw that was running
  a_r10_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  // R6: flag is clear on the first busy cycle
  a_r6_clear_on_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !collision);

  // R4: writes stay inside the active screen
  a_r4_addr_in_range: assert property (@(posedge clk) disable iff (rst)
    fb_we |-> (int'(fb_addr) < (hires_q ? HI_BYTES : LO_BYTES)));

  // R12: each write follows a read of the same byte two cycles earlier
  a_r12_rmw_order: assert property (@(posedge clk) disable iff (rst)
    fb_we |-> ($past(fb_rd, 2) && ($past(fb_addr, 2) == fb_addr)));

  // R12: one memory operation per cycle
  a_r12_one_port_op: assert property (@(posedge clk) disable iff (rst)
    $onehot0({spr_rd, fb_rd, fb_we}));

endmodule

// File: tb/tb_sprite_blitter.sv
module tb_sprite_blitter;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  logic        clk, rst, start;
  logic [7:0]  x_in, y_in;
  logic [3:0]  n_in;
  logic [11:0] base_in;
  logic        hires_in, wrap_in;
  logic        spr_rd;
  logic [11:0] spr_addr;
  logic [7:0]  spr_data;
  logic        fb_rd, fb_we;
  logic [9:0]  fb_addr;
  logic [7:0]  fb_wdata, fb_rdata;
  logic        busy, done, collision;

  sprite_blitter dut (
    .clk(clk), .rst(rst), .start(start), .x_in(x_in), .y_in(y_in),
    .n_in(n_in), .base_in(base_in), .hires_in(hires_in), .wrap_in(wrap_in),
    .spr_rd(spr_rd), .spr_addr(spr_addr), .spr_data(spr_data),
    .fb_rd(fb_rd), .fb_we(fb_we), .fb_addr(fb_addr), .fb_wdata(fb_wdata),
    .fb_rdata(fb_rdata), .busy(busy), .done(done), .collision(collision)
  );

  typedef struct packed {
    logic [7:0]  x;
    logic [7:0]  y;
    logic [3:0]  n;
    logic [11:0] base;
    logic        hi;
    logic        wr;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{8'd3,   8'd2,   4'd5, 12'd0,   1'b0, 1'b0},  // R3 R4 unaligned
    '{8'd3,   8'd2,   4'd5, 12'd0,   1'b0, 1'b0},  // R5 redraw erases
    '{8'd62,  8'd30,  4'd4, 12'd16,  1'b0, 1'b0},  // R8 clip corner, R6
    '{8'd62,  8'd30,  4'd4, 12'd16,  1'b0, 1'b1},  // R7 wrap corner
    '{8'd200, 8'd100, 4'd3, 12'd40,  1'b1, 1'b0},  // R2 modulo hires
    '{8'd120, 8'd60,  4'd0, 12'd64,  1'b1, 1'b1},  // R9 big wrap
    '{8'd121, 8'd5,   4'd0, 12'd64,  1'b1, 1'b0},  // R9 big clip
    '{8'd0,   8'd0,   4'd1, 12'd100, 1'b0, 1'b0},  // R4 aligned
    '{8'd70,  8'd33,  4'd2, 12'd50,  1'b0, 1'b0},  // R2 modulo lores
    '{8'd16,  8'd8,   4'd0, 12'd64,  1'b0, 1'b0}   // R9 big lores
  };

  logic [7:0] fbm  [1024];
  logic [7:0] smem [256];
  logic [7:0] efb  [1024];
  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 1024; i++) fbm[i] <= 8'h00;
    end else if (fb_we) begin
      fbm[fb_addr] <= fb_wdata;
    end
    if (fb_rd) fb_rdata <= fbm[fb_addr];
    if (spr_rd) spr_data <= smem[spr_addr[7:0]];
  end

  task automatic check_int(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Pixel-level reference model of one draw.
  task automatic model(vec_t v, output bit coll);
    int w, h, wb, xs, ys, rows, sw, px, py, addr;
    logic [15:0] word;
    logic [7:0] mask;
    w = v.hi ? 128 : 64;
    h = v.hi ? 64 : 32;
    wb = w / 8;
    xs = int'(v.x) % w;
    ys = int'(v.y) % h;
    rows = (v.n == 0) ? 16 : int'(v.n);
    sw = (v.n == 0) ? 16 : 8;
    coll = 0;
    for (int r = 0; r < rows; r++) begin
      if (sw == 16) word = {smem[(int'(v.base) + 2*r) % 256], smem[(int'(v.base) + 2*r + 1) % 256]};
      else word = {8'h00, smem[(int'(v.base) + r) % 256]};
      for (int i = 0; i < sw; i++) begin
        if (word[sw-1-i]) begin
          px = xs + i;
          py = ys + r;
          if (v.wr) begin
            px = px % w;
            py = py % h;
          end
          if (px < w && py < h) begin
            addr = py * wb + px / 8;
            mask = 8'h80 >> (px % 8);
            if ((efb[addr] & mask) != 0) coll = 1;
            efb[addr] = efb[addr] ^ mask;
          end
        end
      end
    end
  endtask

  task automatic fb_compare(string tag);
    int mism = 0;
    for (int i = 0; i < 1024; i++) if (fbm[i] !== efb[i]) mism++;
    check_int(tag, mism, 0);
  endtask

  // Launch a draw; returns cycles until done and width of the done pulse.
  task automatic launch(vec_t v, output int wait_cyc, output int done_len);
    @(negedge clk);
    x_in = v.x; y_in = v.y; n_in = v.n; base_in = v.base;
    hires_in = v.hi; wrap_in = v.wr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_cyc = 0;
    while (!done && wait_cyc < 3000) begin
      @(negedge clk);
      wait_cyc++;
    end
    done_len = 0;
    while (done) begin
      done_len++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ecoll;
    int wc, dl, extra;
    vec_t wv, iv;
    string tag;
    for (int i = 0; i < 256; i++) smem[i] = 8'((i * 29 + 7) ^ (i << 3)) | 8'h01;
    for (int i = 0; i < 1024; i++) efb[i] = 8'h00;
    rst = 1'b1; start = 1'b0; x_in = '0; y_in = '0; n_in = '0; base_in = '0;
    hires_in = 1'b0; wrap_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_int("R1 busy after reset", int'(busy), 0);
    check_int("R1 done after reset", int'(done), 0);
    check_int("R1 collision after reset", int'(collision), 0);
    check_int("R1 ports idle after reset", int'({spr_rd, fb_rd, fb_we}), 0);

    for (int v = 0; v < NVEC; v++) begin
      model(VECS[v], ecoll);
      launch(VECS[v], wc, dl);
      $sformat(tag, "R4 R8 vector %0d framebuffer", v);
      fb_compare(tag);
      $sformat(tag, "R5 R6 vector %0d collision", v);
      check_int(tag, int'(collision), int'(ecoll));
      $sformat(tag, "R10 vector %0d done width", v);
      check_int(tag, dl, 1);
      check_int("R10 busy low after done", int'(busy), 0);
    end

    // R10: busy rises the cycle after start
    @(negedge clk);
    wv = '{8'd10, 8'd4, 4'd3, 12'd120, 1'b0, 1'b0};
    x_in = wv.x; y_in = wv.y; n_in = wv.n; base_in = wv.base;
    hires_in = wv.hi; wrap_in = wv.wr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check_int("R10 busy after start", int'(busy), 1);
    model(wv, ecoll);
    // R11: competing start mid-draw with other parameters
    repeat (4) @(negedge clk);
    iv = '{8'd40, 8'd20, 4'd6, 12'd200, 1'b1, 1'b1};
    x_in = iv.x; y_in = iv.y; n_in = iv.n; base_in = iv.base;
    hires_in = iv.hi; wrap_in = iv.wr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wc = 0;
    while (!done && wc < 3000) begin
      @(negedge clk);
      wc++;
    end
    @(negedge clk);
    fb_compare("R11 framebuffer after ignored start");
    check_int("R11 collision of kept draw", int'(collision), int'(ecoll));
    extra = 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (done || busy) extra++;
    end
    check_int("R11 no second draw", extra, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule